// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the programming and acknowledge logic of an eight-line interrupt controller. Software talks to it through two byte-wide addresses. The even address (bus_addr = 0) takes control words. The odd address (bus_addr = 1) takes the data words of the setup sequence and, once setup is done, the mask.

The block keeps the setup state, the mask register, the in-service register, the vector base and the rotation base. It also keeps the mode flags for automatic end-of-interrupt, rotation on automatic end-of-interrupt, cascade-nested priority, special mask, read selection and one-shot polling.

An internal request latch records rising edges on the interrupt lines. A rotating priority resolver picks the line to present. The sequencer clears latched requests when they are taken, and it drives the processor request output. When the processor pulses acknowledge, the sequencer returns a vector made of the base and the winning line number.

Top module: `pic_cmd_seq`

## Requirements
- R1: An even-address write with bit 4 set starts setup. It clears mask, in-service, vector base, rotation base, all mode flags and all latched requests, and it forces intr low in the following cycle. Bit 0 of that word records whether a mode word will follow.
- R2: During setup, the first odd-address write stores the vector base as data AND 0xF8. The second odd-address write ends setup, unless a mode word was announced. The optional third write sets cascade-nested mode from bit 4 and automatic end-of-interrupt from bit 1.
- R3: Outside setup, an odd-address write loads the mask. A masked line never raises intr. When not polling, an odd-address read returns the mask.
- R4: A line is latched as pending only on a 0-to-1 transition. A line held high does not latch again after its request has been taken.
- R5: The line with the lowest rank ((line - rotation base) mod 8) wins among pending, unmasked lines. intr is high only when that rank is strictly lower than the lowest rank in service.
- R6: An acknowledge pulse with a winning line returns vec_out = base | line in the next cycle. It sets that line's in-service bit and clears its pending bit.
- R7: An acknowledge pulse with no winning line returns base | 7 and changes no register.
- R8: Command code 1 in bits 7:5 clears the in-service bit of the lowest rank. Code 5 does the same and also sets the rotation base to that line + 1.
- R9: Code 3 clears the in-service bit of the line in bits 2:0. Code 7 does that and also sets the rotation base to that line + 1. Code 6 sets the rotation base to bits 2:0 + 1. Code 2 changes nothing.
- R10: With automatic end-of-interrupt on, an acknowledge leaves the in-service register unchanged. Code 4 turns on rotation at acknowledge, which then sets the rotation base to line + 1. Code 0 turns it off.
- R11: An even-address write with bit 4 clear and bit 3 set is a mode-select word. When its bit 1 is set, bit 0 chooses what even-address reads return: 1 gives in-service, 0 gives pending. Read data appears on bus_rdata in the cycle after bus_rd.
- R12: Bit 2 of the mode-select word arms polling. The next read returns the winning line number, or 7 if there is none, and clears that line's pending and in-service bits. Polling is then disarmed.
- R13: In cascade-nested mode, an in-service bit on the cascade line (line 2) is left out of the current-priority comparison. A new request on that line can then interrupt again.
- R14: Bits 6 and 5 of the mode-select word control special mask: bit 6 enables the update and bit 5 gives the new value. While special mask is on, in-service bits of masked lines are left out of the current-priority comparison.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Interrupt request lines, edge-latched |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_addr | input | 1 | 0 = control address, 1 = data/mask address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| inta | input | 1 | Acknowledge pulse from the processor |
| vec_out | output | 8 | Vector, valid the cycle after inta |
| intr | output | 1 | Interrupt request to the processor |

## Verification
The hardest states to reach from the ports are the ones where the rotation base has been moved. This happens through the rotate-on-EOI codes and through rotation at automatic acknowledge. In those states, a wrong rotation value can still pick the same winner by chance.

The stimulus first places the base where it wants through explicit rotation commands. It then raises pairs of lines in the same cycle, chosen so that the correct base and the most likely wrong bases pick different winners.

The cascade-nested and special-mask cases are reached in a similar way. A line is acknowledged so that it stays in service. A competing request is then raised, and intr is compared before and after the mode takes effect.

// File: rtl/pic_seq_pkg.sv
package pic_seq_pkg;
  localparam int LINES = 8;
  localparam int IDXW  = $clog2(LINES);

  typedef logic [IDXW-1:0]  line_t;
  typedef logic [LINES-1:0] lvec_t;
  typedef logic [IDXW:0]    rank_t;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_BASE = 2'd1,
    ST_SKIP = 2'd2,
    ST_MODE = 2'd3
  } step_e;

  typedef enum logic [2:0] {
    CMD_RAEOI_OFF = 3'd0,
    CMD_NS_EOI    = 3'd1,
    CMD_NOP       = 3'd2,
    CMD_SP_EOI    = 3'd3,
    CMD_RAEOI_ON  = 3'd4,
    CMD_NS_ROT    = 3'd5,
    CMD_SET_ROT   = 3'd6,
    CMD_SP_ROT    = 3'd7
  } cmd_e;

  localparam rank_t NO_RANK = rank_t'(LINES);

  // Rank of the best set bit in v, counted from rotation base; NO_RANK if empty.
  function automatic rank_t rank_of(lvec_t v, line_t base);
    rank_t r;
    r = NO_RANK;
    for (int i = LINES - 1; i >= 0; i--) begin
      line_t k;
      k = line_t'(i) + base;
      if (v[k]) r = rank_t'(i);
    end
    return r;
  endfunction

  function automatic line_t line_of(rank_t r, line_t base);
    return line_t'(r[IDXW-1:0] + base);
  endfunction

  function automatic line_t after(line_t l);
    return line_t'(l + 1'b1);
  endfunction
endpackage

// File: rtl/pic_req_latch.sv
module pic_req_latch
  import pic_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  flush,
  input  lvec_t lines_in,
  input  lvec_t clr,
  output lvec_t pend
);
  lvec_t last_q;
  lvec_t pend_q;
  lvec_t rise;

  assign rise = lines_in & ~last_q;
  assign pend = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      pend_q <= '0;
    end else if (flush) begin
      last_q <= '0;
      pend_q <= '0;
    end else begin
      last_q <= lines_in;
      pend_q <= (pend_q & ~clr) | rise;
    end
  end
endmodule

// File: rtl/pic_prio_resolver.sv
module pic_prio_resolver
  import pic_seq_pkg::*;
#(
  parameter int CASC_LINE = 2
) (
  input  lvec_t pend,
  input  lvec_t imr,
  input  lvec_t isr,
  input  line_t base,
  input  logic  sfnm,
  input  logic  smask,
  output logic  int_valid,
  output line_t int_line
);
  lvec_t req;
  lvec_t svc;
  rank_t req_rank;
  rank_t svc_rank;

  always_comb begin
    req = pend & ~imr;
    svc = isr;
    if (sfnm)  svc[CASC_LINE] = 1'b0;
    if (smask) svc = svc & ~imr;
  end

  assign req_rank  = rank_of(req, base);
  assign svc_rank  = rank_of(svc, base);
  assign int_valid = req_rank < svc_rank;
  assign int_line  = line_of(req_rank, base);
endmodule

// File: rtl/pic_cmd_seq.sv
module pic_cmd_seq
  import pic_seq_pkg::*;
#(
  parameter int CASC_LINE = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] irq_in,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       inta,
  output logic [7:0] vec_out,
  output logic       intr
);
  localparam int VBW = 8 - IDXW;

  lvec_t imr_q, imr_d, isr_q, isr_d, pend, clr_d;
  logic [VBW-1:0] vbase_q, vbase_d;
  line_t rot_q, rot_d;
  logic aeoi_q, aeoi_d, raeoi_q, raeoi_d, sfnm_q, sfnm_d;
  logic rsel_q, rsel_d, poll_q, poll_d, smask_q, smask_d, want4_q, want4_d;
  step_e step_q, step_d;
  logic [7:0] rdata_q, rdata_d, vec_q, vec_d;
  logic flush;

  logic  int_valid;
  line_t int_line;

  // named events
  logic  wr_init, wr_ocw3, wr_cmd, wr_data, ack_take, poll_take;
  cmd_e  cmd;
  rank_t ns_rank;
  line_t ns_line, sel_line;

  assign wr_init   = bus_wr && !bus_addr && bus_wdata[4];
  assign wr_ocw3   = bus_wr && !bus_addr && !bus_wdata[4] && bus_wdata[3];
  assign wr_cmd    = bus_wr && !bus_addr && !bus_wdata[4] && !bus_wdata[3];
  assign wr_data   = bus_wr && bus_addr;
  assign ack_take  = inta && int_valid;
  assign poll_take = bus_rd && poll_q && int_valid;
  assign cmd       = cmd_e'(bus_wdata[7:5]);
  assign ns_rank   = rank_of(isr_q, rot_q);
  assign ns_line   = line_of(ns_rank, rot_q);
  assign sel_line  = line_t'(bus_wdata[IDXW-1:0]);

  pic_req_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .lines_in (irq_in),
    .clr      (clr_d),
    .pend     (pend)
  );

  pic_prio_resolver #(.CASC_LINE(CASC_LINE)) u_prio (
    .pend      (pend),
    .imr       (imr_q),
    .isr       (isr_q),
    .base      (rot_q),
    .sfnm      (sfnm_q),
    .smask     (smask_q),
    .int_valid (int_valid),
    .int_line  (int_line)
  );

  always_comb begin
    imr_d = imr_q;  isr_d = isr_q;  vbase_d = vbase_q;  rot_d = rot_q;
    aeoi_d = aeoi_q;  raeoi_d = raeoi_q;  sfnm_d = sfnm_q;  rsel_d = rsel_q;
    poll_d = poll_q;  smask_d = smask_q;  want4_d = want4_q;  step_d = step_q;
    rdata_d = rdata_q;  vec_d = vec_q;  clr_d = '0;  flush = 1'b0;

    // acknowledge
    if (inta) begin
      vec_d = {vbase_q, (int_valid ? int_line : line_t'(LINES - 1))};
      if (ack_take) begin
        clr_d[int_line] = 1'b1;
        if (aeoi_q) begin
          if (raeoi_q) rot_d = after(int_line);
        end else begin
          isr_d[int_line] = 1'b1;
        end
      end
    end

    // read
    if (bus_rd) begin
      if (poll_q) begin
        poll_d  = 1'b0;
        rdata_d = int_valid ? 8'(int_line) : 8'(LINES - 1);
        if (poll_take) begin
          clr_d[int_line] = 1'b1;
          isr_d[int_line] = 1'b0;
        end
      end else if (bus_addr) begin
        rdata_d = imr_q;
      end else begin
        rdata_d = rsel_q ? isr_q : pend;
      end
    end

    // write
    if (wr_init) begin
      flush = 1'b1;
      imr_d = '0;  isr_d = '0;  vbase_d = '0;  rot_d = '0;
      aeoi_d = 1'b0;  raeoi_d = 1'b0;  sfnm_d = 1'b0;  rsel_d = 1'b0;
      poll_d = 1'b0;  smask_d = 1'b0;
      want4_d = bus_wdata[0];
      step_d  = ST_BASE;
    end else if (wr_ocw3) begin
      if (bus_wdata[2]) poll_d  = 1'b1;
      if (bus_wdata[1]) rsel_d  = bus_wdata[0];
      if (bus_wdata[6]) smask_d = bus_wdata[5];
    end else if (wr_cmd) begin
      unique case (cmd)
        CMD_RAEOI_OFF, CMD_RAEOI_ON: raeoi_d = bus_wdata[7];
        CMD_NS_EOI, CMD_NS_ROT: begin
          if (ns_rank != NO_RANK) begin
            isr_d[ns_line] = 1'b0;
            if (cmd == CMD_NS_ROT) rot_d = after(ns_line);
          end
        end
        CMD_SP_EOI:  isr_d[sel_line] = 1'b0;
        CMD_SET_ROT: rot_d = after(sel_line);
        CMD_SP_ROT: begin
          isr_d[sel_line] = 1'b0;
          rot_d = after(sel_line);
        end
        default: ;
      endcase
    end else if (wr_data) begin
      unique case (step_q)
        ST_RUN:  imr_d = bus_wdata;
        ST_BASE: begin
          vbase_d = bus_wdata[7:IDXW];
          step_d  = ST_SKIP;
        end
        ST_SKIP: step_d = want4_q ? ST_MODE : ST_RUN;
        ST_MODE: begin
          sfnm_d = bus_wdata[4];
          aeoi_d = bus_wdata[1];
          step_d = ST_RUN;
        end
        default: step_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imr_q <= '0;  isr_q <= '0;  vbase_q <= '0;  rot_q <= '0;
      aeoi_q <= 1'b0;  raeoi_q <= 1'b0;  sfnm_q <= 1'b0;  rsel_q <= 1'b0;
      poll_q <= 1'b0;  smask_q <= 1'b0;  want4_q <= 1'b0;  step_q <= ST_RUN;
      rdata_q <= '0;  vec_q <= '0;
    end else begin
      imr_q <= imr_d;  isr_q <= isr_d;  vbase_q <= vbase_d;  rot_q <= rot_d;
      aeoi_q <= aeoi_d;  raeoi_q <= raeoi_d;  sfnm_q <= sfnm_d;  rsel_q <= rsel_d;
      poll_q <= poll_d;  smask_q <= smask_d;  want4_q <= want4_d;  step_q <= step_d;
      rdata_q <= rdata_d;  vec_q <= vec_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign vec_out   = vec_q;
  assign intr      = int_valid;
endmodule

// File: rtl/pic_cmd_seq_chk.sv
module pic_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic       bus_addr,
  input logic [7:0] bus_wdata,
  input logic       inta,
  input logic       intr,
  input logic [7:0] vec_out,
  input logic [7:0] imr_q,
  input logic [7:0] isr_q,
  input logic       poll_q,
  input logic       aeoi_q,
  input logic       sfnm_q,
  input logic       smask_q,
  input logic       int_valid,
  input logic [1:0] step_q
);
  AST_INIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr && bus_wdata[4]) |=> (!intr && imr_q == 8'h00 && isr_q == 8'h00)); // R1

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr && step_q == 2'd0) |=> (imr_q == $past(bus_wdata))); // R3

  AST_ACK_SETS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && int_valid && !aeoi_q && !sfnm_q && !smask_q && !bus_wr && !bus_rd)
      |=> ($countones(isr_q) == $countones($past(isr_q)) + 1)); // R6

  AST_SPURIOUS_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !int_valid) |=> (vec_out[2:0] == 3'd7)); // R7

  AST_AEOI_KEEPS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && aeoi_q && !bus_wr && !bus_rd) |=> $stable(isr_q)); // R10

  AST_POLL_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && poll_q && !bus_wr) |=> !poll_q); // R12
endmodule

bind pic_cmd_seq pic_cmd_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .inta      (inta),
  .intr      (intr),
  .vec_out   (vec_out),
  .imr_q     (imr_q),
  .isr_q     (isr_q),
  .poll_q    (poll_q),
  .aeoi_q    (aeoi_q),
  .sfnm_q    (sfnm_q),
  .smask_q   (smask_q),
  .int_valid (int_valid),
  .step_q    (step_q)
);

// File: tb/pic_cmd_seq_tb.sv
module pic_cmd_seq_tb;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0, inta = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata, vec_out;
  logic       intr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [8:0] exp_q[$];
  string      tag_q[$];
  logic       resp_due = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  pic_cmd_seq u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .inta(inta), .vec_out(vec_out), .intr(intr)
  );

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when a response is due
  always @(posedge clk) resp_due <= bus_rd | inta;
  always @(negedge clk) begin
    if (resp_due) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected response", 8'h00, 8'h00);
      end else begin
        logic [8:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk((e[8] ? vec_out : bus_rdata) == e[7:0], t, e[8] ? vec_out : bus_rdata, e[7:0]);
      end
    end
  end

  // driver tasks: start and end on a falling edge
  task automatic wr(input logic a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, input logic [7:0] e, input string tag);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back({1'b0, e}); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic ack(input logic [7:0] e, input string tag);
    inta = 1'b1;
    exp_q.push_back({1'b1, e}); tag_q.push_back(tag);
    @(negedge clk);
    inta = 1'b0;
  endtask

  task automatic lines(input logic [7:0] v);
    irq_in = v;
    @(negedge clk);
  endtask

  task automatic chk_intr(input logic e, input string tag);
    chk(intr == e, tag, {7'd0, intr}, {7'd0, e});
  endtask

  task automatic setup(input logic [7:0] w0, input logic [7:0] base, input logic [7:0] mode);
    wr(1'b0, w0);
    wr(1'b1, base);
    wr(1'b1, 8'h00);
    if (w0[0]) wr(1'b1, mode);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 watchdog expired actual=0x00 expected=0x01");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk_intr(1'b0, "R1 reset intr");
    rd(1'b1, 8'h00, "R1 reset mask");
    rd(1'b0, 8'h00, "R1 reset pending");
    ack(8'h07, "R7 reset spurious");

    // setup with base 0x4D -> 0x48, mode word present
    setup(8'h11, 8'h4D, 8'h00);
    rd(1'b1, 8'h00, "R2 mask after setup");
    wr(1'b1, 8'hA5);
    rd(1'b1, 8'hA5, "R3 mask load");
    wr(1'b1, 8'h00);

    // single request, acknowledge, register reads
    lines(8'h08);
    chk_intr(1'b1, "R5 single request");
    ack(8'h4B, "R6 vector line 3");
    chk_intr(1'b0, "R6 intr after ack");
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h08, "R11 read in-service");
    wr(1'b0, 8'h0A);
    rd(1'b0, 8'h00, "R6 pending cleared");
    lines(8'h08); lines(8'h08);
    rd(1'b0, 8'h00, "R4 held line not relatched");
    chk_intr(1'b0, "R4 held line no intr");

    // nesting and non-specific EOI
    lines(8'h28);
    chk_intr(1'b0, "R5 lower priority blocked");
    lines(8'h2A);
    chk_intr(1'b1, "R5 higher priority preempts");
    ack(8'h49, "R6 vector line 1");
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h0A, "R6 nested in-service");
    wr(1'b0, 8'h20);
    rd(1'b0, 8'h08, "R8 non-specific clears best");
    chk_intr(1'b0, "R8 still blocked by line 3");
    wr(1'b0, 8'h20);
    chk_intr(1'b1, "R8 line 5 released");
    ack(8'h4D, "R6 vector line 5");
    wr(1'b0, 8'h65);
    rd(1'b0, 8'h00, "R9 specific EOI");
    lines(8'h00);

    // rotation commands
    wr(1'b0, 8'hC4);
    lines(8'h50);
    ack(8'h4E, "R9 set rotation picks line 6");
    wr(1'b0, 8'hE6);
    chk_intr(1'b1, "R9 specific rotate released 4");
    ack(8'h4C, "R9 vector line 4");
    wr(1'b0, 8'hA0);
    lines(8'h00);
    lines(8'h21);
    ack(8'h4D, "R8 rotate EOI base 5");
    chk_intr(1'b0, "R5 line 0 below line 5");
    wr(1'b0, 8'h20);
    chk_intr(1'b1, "R8 line 0 released");
    ack(8'h48, "R6 vector line 0");
    wr(1'b0, 8'h40);
    rd(1'b0, 8'h01, "R9 no-op code");
    wr(1'b0, 8'h20);
    rd(1'b0, 8'h00, "R8 cleared line 0");
    wr(1'b0, 8'hC7);
    lines(8'h00);

    // spurious and masking
    ack(8'h4F, "R7 spurious vector");
    wr(1'b1, 8'h01);
    lines(8'h01);
    chk_intr(1'b0, "R3 masked line silent");
    ack(8'h4F, "R7 spurious while masked");
    rd(1'b1, 8'h01, "R3 mask readback");
    wr(1'b1, 8'h00);
    chk_intr(1'b1, "R3 unmask raises");
    ack(8'h48, "R6 vector after unmask");
    wr(1'b0, 8'h20);
    lines(8'h00);

    // poll
    lines(8'h04);
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h02, "R12 poll returns line");
    rd(1'b0, 8'h00, "R12 poll cleared in-service");
    wr(1'b0, 8'h0A);
    rd(1'b0, 8'h00, "R12 poll cleared pending");
    chk_intr(1'b0, "R12 intr after poll");
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h07, "R12 poll with none");
    rd(1'b1, 8'h00, "R12 poll disarmed");
    lines(8'h00);

    // setup drops request; automatic EOI with rotation
    lines(8'h80);
    chk_intr(1'b1, "R5 line 7 request");
    wr(1'b0, 8'h11);
    chk_intr(1'b0, "R1 setup drops intr");
    irq_in = 8'h00;
    wr(1'b1, 8'h80); wr(1'b1, 8'h00); wr(1'b1, 8'h02);
    rd(1'b1, 8'h00, "R1 mask cleared by setup");
    wr(1'b0, 8'h80);
    lines(8'h08);
    ack(8'h83, "R10 auto EOI vector");
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h00, "R10 in-service stays clear");
    lines(8'h1C);
    ack(8'h84, "R10 rotated base 4");
    ack(8'h82, "R10 rotated base 5");
    wr(1'b0, 8'h00);
    lines(8'h00);
    lines(8'h40);
    ack(8'h86, "R10 line 6");
    lines(8'h61);
    ack(8'h85, "R10 rotation stopped");
    ack(8'h80, "R10 last line 0");
    lines(8'h00);

    // setup without mode word
    setup(8'h10, 8'h27, 8'h00);
    wr(1'b1, 8'hF0);
    rd(1'b1, 8'hF0, "R2 short setup then mask");
    wr(1'b0, 8'h0B);
    lines(8'h01);
    ack(8'h20, "R2 base masked to 0x20");
    rd(1'b0, 8'h01, "R1 auto EOI cleared by setup");
    lines(8'h00);

    // cascade-nested
    setup(8'h11, 8'h08, 8'h10);
    lines(8'h04);
    ack(8'h0A, "R13 first line 2");
    lines(8'h00);
    lines(8'h04);
    chk_intr(1'b1, "R13 line 2 again");
    ack(8'h0A, "R13 second line 2");
    lines(8'h00);

    // special mask
    setup(8'h10, 8'h00, 8'h00);
    lines(8'h01);
    ack(8'h00, "R6 vector base 0");
    wr(1'b1, 8'h01);
    lines(8'h21);
    chk_intr(1'b0, "R14 blocked without special mask");
    wr(1'b0, 8'h68);
    chk_intr(1'b1, "R14 special mask unblocks");
    ack(8'h05, "R14 vector line 5");
    wr(1'b0, 8'h48);
    lines(8'h00);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) chk(1'b0, "R6 responses missing", 8'(exp_q.size()), 8'h00);
    finish_run();
  end
endmodule